// File: doc/BRIEF.md
# IR carrier modulating transmitter

This block drives an infrared LED pin from a short queue of pulse durations. Each queued entry holds a 16-bit duration count and a one-bit level, where 1 is a mark and 0 is a space. A programmable divider sets the transmit tick period. The sequencer plays the entries one after another, with no gap between them. Each entry lasts a fixed number of ticks derived from its count.

When modulation is on, one of the two levels is sent as bursts of a carrier and the other is sent as a silent low. The carrier period is sixteen ticks, and a four-bit duty code sets how many of those ticks are high. A polarity bit chooses whether marks or spaces carry the burst. A final inversion bit flips the pin.

The queue is filled through a simple write port. A service request tells the feeding logic when the queue has drained to a chosen watermark. Dropping the transmit enable abandons everything at once.

Top module: `ir_tx_mod`

## Requirements
- R1: After reset, busy, fifo_full and svc_req are 0, and ir_out equals invert_out.
- R2: One transmit tick lasts divider+1 clock cycles. An entry with count c is held for 4*c+4 ticks, counted from the cycle in which it is taken from the queue.
- R3: Entries are played in the order they were written. When an entry ends and another is queued, the next one starts on the same tick boundary, with no gap.
- R4: With mod_enable at 0, the pre-inversion output equals the level of the entry being played (push_level 1 = mark = high).
- R5: The carrier phase advances once per tick and wraps every 16 ticks. It is high in the phases 0 through duty, which is duty+1 of the 16 ticks.
- R6: With mod_enable at 1, the burst is placed on the entry's level. When burst_on_space is 0, marks carry the burst and spaces are low. When it is 1, spaces carry the burst and marks are low.
- R7: ir_out is the pre-inversion level XOR invert_out at all times.
- R8: While enabled, svc_req is 1 when the queue holds at most DEPTH/2 entries and wm_empty is 0. When wm_empty is 1, svc_req is 1 only when the queue is empty. svc_req is 0 while disabled.
- R9: The queue holds DEPTH (8) entries. fifo_full is 1 at DEPTH entries, and a write made while full is discarded.
- R10: When the last entry finishes and the queue is empty, busy falls to 0 and the pre-inversion output idles low with no carrier.
- R11: While tx_enable is 0, the queue is emptied, writes are discarded and busy is 0 from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; low flushes and stops |
| mod_enable | input | 1 | Gate the burst level with the carrier |
| burst_on_space | input | 1 | 0: marks carry the burst, 1: spaces carry it |
| invert_out | input | 1 | Invert the final pin level |
| wm_empty | input | 1 | Service watermark: 0 half empty, 1 empty |
| divider | input | 16 | Tick period minus one, in clock cycles |
| duty | input | 4 | Carrier high phases minus one |
| push_valid | input | 1 | Write one entry this cycle |
| push_count | input | 16 | Entry duration count |
| push_level | input | 1 | Entry level, 1 = mark |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| svc_req | output | 1 | Queue has drained to the watermark |
| busy | output | 1 | An entry is being played |
| ir_out | output | 1 | LED drive level |

## Verification
The case hardest to reach from the ports is a full queue with an overflowing write. The sequencer takes the first entry almost at once, so the queue only fills when writes arrive faster than entries drain. The stimulus sets a large divider so that one entry lasts well over a thousand cycles, then writes eleven entries in quick succession. This reaches full, discards the surplus, and lets the half-empty request be seen as the queue drains. A second hard case is disabling in the middle of an entry. The bench then watches the following cycles to confirm that nothing left in the queue comes back after enable returns.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    // width of one duration count
    localparam int PW_W  = 16;
    // duration counter holds the count with two forced-one low bits
    localparam int REM_W = PW_W + 2;
    // carrier phase counter width (period of 16 ticks)
    localparam int PH_W  = 4;

    typedef struct packed {
        logic            level;
        logic [PW_W-1:0] count;
    } pulse_t;

endpackage

// File: rtl/irtx_tick.sv
module irtx_tick
    import irtx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divider,
    output logic             tick,
    output logic [PH_W-1:0]  phase
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [PH_W-1:0]  ph;
    } tick_st_t;

    tick_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = en && (st_q.cnt >= divider);
        if (!en) begin
            st_d = '0;
        end else if (tick) begin
            st_d.cnt = '0;
            st_d.ph  = st_q.ph + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign phase = st_q.ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (st_q.cnt == '0));

    // R5
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> (st_q.ph == $past(st_q.ph) + 4'd1));

endmodule

// File: rtl/irtx_fifo.sv
module irtx_fifo
    import irtx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  pulse_t                       wdata,
    input  logic                         pop,
    output pulse_t                       rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   fill
);

    localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int  CW   = $clog2(DEPTH + 1);
    localparam bit  POW2 = ((1 << AW) == DEPTH);

    typedef struct packed {
        pulse_t [DEPTH-1:0] mem;
        logic   [AW-1:0]    wp;
        logic   [AW-1:0]    rp;
        logic   [CW-1:0]    fill;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [AW-1:0] wp_inc, rp_inc;
    logic do_push, do_pop;

    generate
        if (POW2) begin : g_pow2
            assign wp_inc = st_q.wp + 1'b1;
            assign rp_inc = st_q.rp + 1'b1;
        end else begin : g_wrap
            assign wp_inc = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            assign rp_inc = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
    endgenerate

    assign empty = (st_q.fill == '0);
    assign full  = (st_q.fill == CW'(DEPTH));
    assign fill  = st_q.fill;
    assign rdata = st_q.mem[st_q.rp];

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.wp   = '0;
            st_d.rp   = '0;
            st_d.fill = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = wp_inc;
            end
            if (do_pop) begin
                st_d.rp = rp_inc;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.fill = st_q.fill + 1'b1;
                2'b01:   st_d.fill = st_q.fill - 1'b1;
                default: st_d.fill = st_q.fill;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> $stable(st_q.fill));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/irtx_seq.sv
module irtx_seq
    import irtx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   tick,
    input  logic   avail,
    input  pulse_t head,
    output logic   pop,
    output logic   active,
    output logic   level
);

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             lvl;
        logic             act;
    } seq_st_t;

    seq_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (!en) begin
            st_d = '0;
        end else if (!st_q.act) begin
            if (avail) begin
                pop      = 1'b1;
                st_d.rem = {head.count, 2'b11};
                st_d.lvl = head.level;
                st_d.act = 1'b1;
            end
        end else if (tick) begin
            if (st_q.rem == '0) begin
                if (avail) begin
                    pop      = 1'b1;
                    st_d.rem = {head.count, 2'b11};
                    st_d.lvl = head.level;
                end else begin
                    st_d.act = 1'b0;
                end
            end else begin
                st_d.rem = st_q.rem - 1'b1;
            end
        end
    end

    assign active = st_q.act;
    assign level  = st_q.lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.act && !tick) |=> $stable(st_q.rem));

    // R10
    idle_when_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.act && tick && (st_q.rem == '0) && !avail) |=> !st_q.act);

endmodule

// File: rtl/ir_tx_mod.sv
module ir_tx_mod
    import irtx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_enable,
    input  logic             mod_enable,
    input  logic             burst_on_space,
    input  logic             invert_out,
    input  logic             wm_empty,
    input  logic [DIV_W-1:0] divider,
    input  logic [PH_W-1:0]  duty,
    input  logic             push_valid,
    input  logic [PW_W-1:0]  push_count,
    input  logic             push_level,
    output logic             fifo_full,
    output logic             svc_req,
    output logic             busy,
    output logic             ir_out
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic            tick;
    logic [PH_W-1:0] phase;
    pulse_t          wr_ent, head;
    logic            empty, full, pop, active, level;
    logic [CW-1:0]   fill;
    logic            carrier_hi, burst_lvl, raw_lvl;

    assign wr_ent.level = push_level;
    assign wr_ent.count = push_count;

    irtx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_enable),
        .divider (divider),
        .tick    (tick),
        .phase   (phase)
    );

    irtx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (!tx_enable),
        .push  (push_valid),
        .wdata (wr_ent),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full),
        .fill  (fill)
    );

    irtx_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (tx_enable),
        .tick   (tick),
        .avail  (!empty),
        .head   (head),
        .pop    (pop),
        .active (active),
        .level  (level)
    );

    always_comb begin
        carrier_hi = (phase <= duty);
        burst_lvl  = level ^ burst_on_space;
        if (!active)        raw_lvl = 1'b0;
        else if (mod_enable) raw_lvl = burst_lvl && carrier_hi;
        else                raw_lvl = level;
        ir_out    = raw_lvl ^ invert_out;
        busy      = active;
        fifo_full = full;
        if (!tx_enable)    svc_req = 1'b0;
        else if (wm_empty) svc_req = empty;
        else               svc_req = (fill <= CW'(HALF));
    end

    // R11
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> !busy);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ir_out == invert_out));

endmodule

// File: tb/ir_tx_mod_tb.sv
module ir_tx_mod_tb;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b0, mod_enable = 1'b0, burst_on_space = 1'b0;
    logic invert_out = 1'b0, wm_empty = 1'b0;
    logic [15:0] divider = '0;
    logic [3:0]  duty = '0;
    logic push_valid = 1'b0, push_level = 1'b0;
    logic [15:0] push_count = '0;
    logic fifo_full, svc_req, busy, ir_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_on = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt = 0, m_ph = 0, m_rem = 0, m_lvl = 0, m_act = 0;
    int q[$];

    always #4 clk = ~clk;

    ir_tx_mod u_dut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .mod_enable(mod_enable),
        .burst_on_space(burst_on_space), .invert_out(invert_out), .wm_empty(wm_empty),
        .divider(divider), .duty(duty), .push_valid(push_valid),
        .push_count(push_count), .push_level(push_level),
        .fifo_full(fifo_full), .svc_req(svc_req), .busy(busy), .ir_out(ir_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // model advance at each rising edge
    always @(posedge clk) begin
        int sz0;
        bit tk;
        int e;
        if (!rst_n || !tx_enable) begin
            m_cnt = 0; m_ph = 0; m_rem = 0; m_lvl = 0; m_act = 0;
            q.delete();
        end else begin
            sz0 = q.size();
            tk  = (m_cnt >= int'(divider));
            if (m_act == 0) begin
                if (sz0 > 0) begin
                    e = q.pop_front();
                    m_rem = (e % 65536) * 4 + 3; m_lvl = e / 65536; m_act = 1;
                end
            end else if (tk) begin
                if (m_rem == 0) begin
                    if (sz0 > 0) begin
                        e = q.pop_front();
                        m_rem = (e % 65536) * 4 + 3; m_lvl = e / 65536;
                    end else begin
                        m_act = 0;
                    end
                end else begin
                    m_rem--;
                end
            end
            if (push_valid && sz0 < DEPTH)
                q.push_back(int'(push_level) * 65536 + int'(push_count));
            if (tk) begin m_cnt = 0; m_ph = (m_ph + 1) % 16; end
            else m_cnt++;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        bit e_full, e_svc, e_raw, e_out;
        if (cmp_on) begin
            e_full = (q.size() == DEPTH);
            e_svc  = tx_enable && (wm_empty ? (q.size() == 0) : (q.size() <= DEPTH / 2));
            if (m_act == 0) e_raw = 1'b0;
            else if (mod_enable) e_raw = ((m_lvl != 0) ^ burst_on_space) && (m_ph <= int'(duty));
            else e_raw = (m_lvl != 0);
            e_out = e_raw ^ invert_out;
            chk(busy == (m_act != 0), cur_req, "busy", busy, m_act);
            chk(fifo_full == e_full, cur_req, "fifo_full", fifo_full, e_full);
            chk(svc_req == e_svc, cur_req, "svc_req", svc_req, e_svc);
            chk(ir_out == e_out, cur_req, "ir_out", ir_out, e_out);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push_one(input int cnt, input bit lvl);
        @(negedge clk); #1;
        push_valid = 1'b1; push_count = 16'(cnt); push_level = lvl;
        @(negedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (m_act == 0 && q.size() == 0) break;
        end
        @(negedge clk); #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(fifo_full == 1'b0, "R1", "fifo_full", fifo_full, 0);
        chk(svc_req == 1'b0, "R1", "svc_req", svc_req, 0);
        chk(ir_out == invert_out, "R1", "ir_out", ir_out, invert_out);
        cmp_on = 1'b1;

        // R2 R3 R4 R10: plain levels, back-to-back entries
        cur_req = "R2,R3,R4,R10";
        #1 tx_enable = 1'b1; divider = 16'd2; mod_enable = 1'b0;
        push_one(1, 1'b1);
        push_one(0, 1'b0);
        push_one(2, 1'b1);
        wait_idle();
        chk(busy == 1'b0, "R10", "busy after drain", busy, 0);
        chk(ir_out == 1'b0, "R10", "idle level", ir_out, 0);

        // R5 R6: carrier on marks, several duty codes
        cur_req = "R5,R6";
        mod_enable = 1'b1; divider = 16'd0; duty = 4'd5;
        push_one(8, 1'b1);
        push_one(4, 1'b0);
        push_one(3, 1'b1);
        wait_idle();
        duty = 4'd0;
        push_one(5, 1'b1);
        wait_idle();
        duty = 4'd15;
        push_one(5, 1'b1);
        wait_idle();

        // R6 R7: burst on spaces with output inversion
        cur_req = "R6,R7";
        burst_on_space = 1'b1; invert_out = 1'b1; duty = 4'd3; divider = 16'd1;
        push_one(4, 1'b1);
        push_one(6, 1'b0);
        wait_idle();
        chk(ir_out == 1'b1, "R7", "inverted idle", ir_out, 1);
        burst_on_space = 1'b0; invert_out = 1'b0;

        // R8 R9: fill past capacity with a slow tick
        cur_req = "R8,R9";
        mod_enable = 1'b0; divider = 16'd100; wm_empty = 1'b0;
        for (int i = 0; i < 11; i++) push_one(3, i[0]);
        chk(fifo_full == 1'b1, "R9", "fifo_full after overfill", fifo_full, 1);
        chk(svc_req == 1'b0, "R8", "svc_req when full", svc_req, 0);
        wait_idle();
        wm_empty = 1'b1; divider = 16'd3;
        push_one(2, 1'b1);
        push_one(1, 1'b0);
        push_one(2, 1'b1);
        wait_idle();
        chk(svc_req == 1'b1, "R8", "svc_req at empty", svc_req, 1);

        // R11: disable mid-entry flushes
        cur_req = "R11";
        divider = 16'd5; wm_empty = 1'b0;
        push_one(4, 1'b1);
        push_one(4, 1'b0);
        push_one(4, 1'b1);
        repeat (30) @(negedge clk);
        #1 tx_enable = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R11", "busy after disable", busy, 0);
        chk(svc_req == 1'b0, "R11", "svc_req while disabled", svc_req, 0);
        #1 tx_enable = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R11", "no replay after enable", busy, 0);
        end

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule